// File: doc/BRIEF.md
# Wait-State Memory Bus Sequencer

This block sits between a CPU load/store port and a slow memory bus. It takes one request of 1, 2 or 4 bytes and issues it as a series of bus beats. The bus can be configured as 8 or 16 bits wide. Each beat is held on the bus for a programmable number of extra wait cycles. When the bus is 16 bits wide and the address is odd, the transfer is split so that only whole aligned halfwords travel as full-width beats. A byte left over at either end of the transfer travels as a single-lane beat.

The CPU side presents an address, a size code, a direction, write data and a valid flag. It receives a one-cycle done pulse with the read data assembled little-endian. After each request the block reports how many bus cycles the request took. For aligned requests that count equals (wait states + 1) multiplied by the rounded-up ratio of request bytes to bus bytes. A new request can be taken in the cycle after the done pulse.

Top module: `wait_bus_seq`

## Requirements
- R1: After reset, reqReady is 1, busValid is 0, busStrb is 0, reqDone is 0 and cycleCount is 0.
- R2: Every beat keeps busValid, busAddr and busStrb steady for exactly waitStates+1 cycles. waitStates is sampled when a request is accepted, and later changes to it do not affect the request in flight.
- R3: The size code reqSize maps 0 to 1 byte, 1 to 2 bytes, and 2 or 3 to 4 bytes. On an aligned address the number of beats is ceil(bytes / bus bytes). busWide=1 selects a 2-byte bus and busWide=0 selects a 1-byte bus.
- R4: On the 8-bit bus every beat moves one byte on lanes [7:0] with busStrb=01, and busAddr rises by 1 from beat to beat.
- R5: On the 16-bit bus, a full-width beat has busStrb=11 and an even busAddr. A single byte at an even address uses lanes [7:0] with busStrb=01.
- R6: On the 16-bit bus with an odd start address, the first beat carries one byte on lanes [15:8] with busStrb=10. Middle beats are full-width. A remaining final byte goes on lanes [7:0] with busStrb=01. This gives 1, 2 and 3 beats for sizes of 1, 2 and 4 bytes.
- R7: Read data is assembled little-endian: the byte at the request address lands in reqRdata[7:0]. Bytes above the request size read as zero.
- R8: Write data is placed little-endian, so memory byte addr+i receives reqWdata[8i+7:8i].
- R9: reqDone is high for exactly one cycle, in the cycle after the last beat. reqRdata is valid in that cycle, and reqReady is 1 in the following cycle.
- R10: From the done cycle until the next accept, cycleCount holds beats × (waitStates+1).
- R11: A reqValid raised while a request is in flight is ignored: no extra beats and no later accept result from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus; sampled at accept |
| waitStates | input | WS_W | Extra cycles per beat; sampled at accept |
| reqValid | input | 1 | Request present |
| reqAddr | input | ADDR_W | Byte address of request |
| reqSize | input | 2 | 0:1 byte, 1:2 bytes, 2/3:4 bytes |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 32 | Write data, little-endian |
| reqReady | output | 1 | Block idle; request accepted when reqValid is also high |
| reqDone | output | 1 | One-cycle completion pulse |
| reqRdata | output | 32 | Assembled read data, valid with reqDone |
| busValid | output | 1 | Bus strobe, high during every beat cycle |
| busWrite | output | 1 | Beat direction |
| busAddr | output | ADDR_W | Byte address of the beat's lowest active byte |
| busStrb | output | 2 | Byte lane enables |
| busWdata | output | 16 | Beat write data on lanes |
| busRdata | input | 16 | Beat read data, sampled on the beat's last cycle |
| cycleCount | output | CNT_W | Bus cycles used by the latest request |

## Verification
The bench targets odd start addresses on the 16-bit bus. A sequencer that ignored alignment would drive a full-width beat at an odd address. It would then corrupt the neighbouring byte or read the two bytes in swapped order, and the strobe, beat-count and data checks would catch this. The bench also runs the maximum wait count with 4-byte requests on the 8-bit bus, where an off-by-one in the wait counter shows up as a wrong cycleCount and a shifted done pulse. The bench also raises reqValid and changes waitStates while a request is in flight. A design that re-sampled waitStates or accepted the stray request would show a different latency or would start an unexpected beat after done.

// File: rtl/wsb_pkg.sv
package wsb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_DONE = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch a new request
    logic advance;  // current beat ends this cycle
  } seqStrobe_t;

  function automatic logic [2:0] sizeToBytes(input logic [1:0] code);
    case (code)
      2'd0:    sizeToBytes = 3'd1;
      2'd1:    sizeToBytes = 3'd2;
      default: sizeToBytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/wsb_ctrl.sv
module wsb_ctrl
  import wsb_pkg::*;
#(
  parameter int WS_W  = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [WS_W-1:0]  waitStates,
  input  logic             isLast,
  output seqStrobe_t       strobes,
  output logic             busValid,
  output logic             reqReady,
  output logic             reqDone,
  output logic [CNT_W-1:0] cycleCount
);

  seqState_t        state;
  logic [WS_W-1:0]  wsLatched;
  logic [WS_W-1:0]  waitCnt;
  logic [CNT_W-1:0] cycCnt;
  logic             beatEnd;

  assign beatEnd = (state == ST_BEAT) && (waitCnt == wsLatched);

  always_comb begin
    strobes         = '0;
    strobes.load    = (state == ST_IDLE) && reqValid;
    strobes.advance = beatEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wsLatched <= '0;
      waitCnt   <= '0;
      cycCnt    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state     <= ST_BEAT;
            wsLatched <= waitStates;
            waitCnt   <= '0;
            cycCnt    <= '0;
          end
        end
        ST_BEAT: begin
          cycCnt <= cycCnt + 1'b1;
          if (beatEnd) begin
            waitCnt <= '0;
            if (isLast) state <= ST_DONE;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busValid   = (state == ST_BEAT);
  assign reqReady   = (state == ST_IDLE);
  assign reqDone    = (state == ST_DONE);
  assign cycleCount = cycCnt;

endmodule

// File: rtl/wsb_datapath.sv
module wsb_datapath
  import wsb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobes,
  input  logic              busValid,
  input  logic              busWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [BUS_W-1:0]  busRdata,
  output logic              isLast,
  output logic [DATA_W-1:0] reqRdata,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busStrb,
  output logic [BUS_W-1:0]  busWdata
);

  localparam int DATA_BYTES = DATA_W / 8;
  localparam int SH_W       = $clog2(DATA_W);

  logic [ADDR_W-1:0] curAddr;
  logic [2:0]        remBytes;
  logic [2:0]        offs;
  logic [DATA_W-1:0] wdataR;
  logic [DATA_W-1:0] rdataR;
  logic [DATA_W-1:0] rdNext;
  logic [DATA_W-1:0] wShift;
  logic              wideR;
  logic              writeR;
  logic              twoByte;
  logic              oddLane;
  logic [2:0]        beatBytes;
  logic [1:0]        laneStrb;
  logic [7:0]        rb0;
  logic [SH_W-1:0]   shAmt;

  assign twoByte   = wideR && !curAddr[0] && (remBytes >= 3'd2);
  assign oddLane   = wideR && curAddr[0];
  assign beatBytes = twoByte ? 3'd2 : 3'd1;
  assign isLast    = (remBytes == beatBytes);

  always_comb begin
    if (twoByte)      laneStrb = 2'b11;
    else if (oddLane) laneStrb = 2'b10;
    else              laneStrb = 2'b01;
  end

  // write lanes
  assign shAmt  = SH_W'({offs, 3'b000});
  assign wShift = wdataR >> shAmt;

  always_comb begin
    busWdata = '0;
    if (busValid) begin
      if (twoByte)      busWdata = {wShift[15:8], wShift[7:0]};
      else if (oddLane) busWdata = {wShift[7:0], 8'h00};
      else              busWdata = {8'h00, wShift[7:0]};
    end
  end

  // read assembly
  assign rb0 = oddLane ? busRdata[15:8] : busRdata[7:0];

  always_comb begin
    rdNext = rdataR;
    for (int i = 0; i < DATA_BYTES; i++) begin
      if (3'(i) == offs)
        rdNext[i*8 +: 8] = rb0;
      else if (twoByte && (3'(i) == offs + 3'd1))
        rdNext[i*8 +: 8] = busRdata[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      remBytes <= '0;
      offs     <= '0;
      wdataR   <= '0;
      rdataR   <= '0;
      wideR    <= 1'b0;
      writeR   <= 1'b0;
    end else if (strobes.load) begin
      curAddr  <= reqAddr;
      remBytes <= sizeToBytes(reqSize);
      offs     <= '0;
      wdataR   <= reqWdata;
      rdataR   <= '0;
      wideR    <= busWide;
      writeR   <= reqWrite;
    end else if (strobes.advance) begin
      curAddr  <= curAddr + ADDR_W'(beatBytes);
      remBytes <= remBytes - beatBytes;
      offs     <= offs + beatBytes;
      if (!writeR) rdataR <= rdNext;
    end
  end

  assign reqRdata = rdataR;
  assign busWrite = writeR;
  assign busAddr  = curAddr;
  assign busStrb  = busValid ? laneStrb : 2'b00;

endmodule

// File: rtl/wait_bus_seq.sv
module wait_bus_seq
  import wsb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WS_W   = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWide,
  input  logic [WS_W-1:0]   waitStates,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [31:0]       reqWdata,
  output logic              reqReady,
  output logic              reqDone,
  output logic [31:0]       reqRdata,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busStrb,
  output logic [15:0]       busWdata,
  input  logic [15:0]       busRdata,
  output logic [CNT_W-1:0]  cycleCount
);

  seqStrobe_t strobes;
  logic       isLast;

  wsb_ctrl #(.WS_W(WS_W), .CNT_W(CNT_W)) ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .waitStates(waitStates),
    .isLast(isLast), .strobes(strobes), .busValid(busValid),
    .reqReady(reqReady), .reqDone(reqDone), .cycleCount(cycleCount)
  );

  wsb_datapath #(.ADDR_W(ADDR_W), .DATA_W(32), .BUS_W(16)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busValid(busValid),
    .busWide(busWide), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .busRdata(busRdata),
    .isLast(isLast), .reqRdata(reqRdata), .busWrite(busWrite),
    .busAddr(busAddr), .busStrb(busStrb), .busWdata(busWdata)
  );

endmodule

// File: rtl/wsb_checker.sv
module wsb_checker #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqDone,
  input logic              busValid,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busStrb,
  input logic [CNT_W-1:0]  cycleCount
);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);

  // R9
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> reqReady);

  // R5
  full_beat_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busStrb == 2'b11) |-> !busAddr[0]);

  // R2
  strobe_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (busStrb != 2'b00));

  // R2
  accept_starts_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> busValid);

  // R10
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !reqValid) |=> $stable(cycleCount));

  // R11
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> !reqReady);

endmodule

bind wait_bus_seq wsb_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqDone(reqDone), .busValid(busValid), .busAddr(busAddr),
  .busStrb(busStrb), .cycleCount(cycleCount)
);

// File: tb/tb_wait_bus_seq.sv
module tb_wait_bus_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int WS_W   = 4;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rstN;
  logic              busWide;
  logic [WS_W-1:0]   waitStates;
  logic              reqValid;
  logic [ADDR_W-1:0] reqAddr;
  logic [1:0]        reqSize;
  logic              reqWrite;
  logic [31:0]       reqWdata;
  logic              reqReady, reqDone, busValid, busWrite;
  logic [31:0]       reqRdata;
  logic [ADDR_W-1:0] busAddr;
  logic [1:0]        busStrb;
  logic [15:0]       busWdata, busRdata;
  logic [CNT_W-1:0]  cycleCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  wait_bus_seq #(.ADDR_W(ADDR_W), .WS_W(WS_W), .CNT_W(CNT_W)) dut (.*);

  logic [7:0] mem    [256];
  logic [7:0] refMem [256];

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // memory device
  assign busRdata = busWide
    ? {mem[{busAddr[7:1], 1'b1}], mem[{busAddr[7:1], 1'b0}]}
    : {8'h00, mem[busAddr[7:0]]};

  always @(posedge clk) begin
    if (busValid && busWrite) begin
      if (busWide) begin
        if (busStrb[0]) mem[{busAddr[7:1], 1'b0}] <= busWdata[7:0];
        if (busStrb[1]) mem[{busAddr[7:1], 1'b1}] <= busWdata[15:8];
      end else begin
        mem[busAddr[7:0]] <= busWdata[7:0];
      end
    end
  end

  // beat monitor
  int busCycles, beatCnt, badStrb, badHold, runLen, wsNow;
  logic prevV = 1'b0;
  logic [ADDR_W-1:0] prevAddr = '0;
  logic [1:0] prevStrb = '0;

  always @(negedge clk) begin
    if (busValid) begin
      busCycles++;
      if (!prevV || busAddr != prevAddr) begin
        if (prevV && runLen != wsNow + 1) badHold++;
        beatCnt++;
        runLen = 1;
      end else begin
        runLen++;
        if (busStrb != prevStrb) badHold++;
      end
      if (busWide) begin
        if (busAddr[0] ? (busStrb != 2'b10) : (busStrb == 2'b10 || busStrb == 2'b00)) badStrb++;
      end else if (busStrb != 2'b01) badStrb++;
    end else if (prevV && runLen != wsNow + 1) begin
      badHold++;
    end
    prevV = busValid; prevAddr = busAddr; prevStrb = busStrb;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int nBytes(input logic [1:0] code);
    return code == 2'd0 ? 1 : code == 2'd1 ? 2 : 4;
  endfunction

  function automatic int expBeats(input bit wide, input logic [ADDR_W-1:0] a, input int n);
    if (!wide) return n;
    if (a[0]) return n == 1 ? 1 : n == 2 ? 2 : 3;
    return (n + 1) / 2;
  endfunction

  task automatic doReq(input bit wide, input logic [3:0] ws, input logic [ADDR_W-1:0] a,
                       input logic [1:0] sz, input bit wr, input logic [31:0] wd,
                       input bit poke);
    int n, beats, k;
    logic [31:0] expRd;
    n = nBytes(sz);
    beats = expBeats(wide, a, n);
    expRd = '0;
    for (int i = 0; i < n; i++) expRd[i*8 +: 8] = refMem[8'(a + ADDR_W'(i))];
    busCycles = 0; beatCnt = 0; badStrb = 0; badHold = 0; runLen = 0; wsNow = int'(ws);
    busWide = wide; waitStates = ws; reqAddr = a; reqSize = sz;
    reqWrite = wr; reqWdata = wd; reqValid = 1'b1;
    k = 0;
    while (k < 200) begin
      @(negedge clk);
      k++;
      if (k == 1) reqValid = 1'b0;
      if (poke && k == 2) begin reqValid = 1'b1; reqAddr = a + 16'd40; waitStates = ~ws; end
      if (poke && k == 3) reqValid = 1'b0;
      if (reqDone) break;
    end
    reqValid = 1'b0;
    // R9: done one cycle after last beat cycle
    check(k == beats * (int'(ws) + 1) + 1, "R9", "done latency", k, beats * (int'(ws) + 1) + 1);
    // R3 R4 R6: beat count
    check(beatCnt == beats, "R3", "beat count", beatCnt, beats);
    // R2: every beat held ws+1 cycles
    check(badHold == 0, "R2", "beat hold errors", badHold, 0);
    // R5 R6 R4: strobe/lane rules
    check(badStrb == 0, wide ? (a[0] ? "R6" : "R5") : "R4", "strobe errors", badStrb, 0);
    // R10
    check(cycleCount == CNT_W'(beats * (int'(ws) + 1)), "R10", "cycleCount",
          cycleCount, beats * (int'(ws) + 1));
    if (!wr) begin
      // R7
      check(reqRdata == expRd, "R7", "read data", reqRdata, expRd);
    end else begin
      for (int i = 0; i < n; i++) refMem[8'(a + ADDR_W'(i))] = wd[i*8 +: 8];
    end
    @(negedge clk);
    check(reqReady && !reqDone, "R9", "ready after done", {reqReady, reqDone}, 2'b10);
    if (wr) begin
      for (int i = 0; i < n; i++)
        // R8
        check(mem[8'(a + ADDR_W'(i))] == wd[i*8 +: 8], "R8", "written byte",
              mem[8'(a + ADDR_W'(i))], wd[i*8 +: 8]);
    end
    if (poke) begin
      @(negedge clk);
      // R11: stray request left no trace
      check(!busValid && reqReady, "R11", "no late accept", busValid, 0);
      check(cycleCount == CNT_W'(beats * (int'(ws) + 1)), "R11", "count unchanged",
            cycleCount, beats * (int'(ws) + 1));
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 5);
      refMem[i] = mem[i];
    end
    rstN = 1'b0; busWide = 1'b1; waitStates = '0; reqValid = 1'b0;
    reqAddr = '0; reqSize = '0; reqWrite = 1'b0; reqWdata = '0;
    repeat (3) @(negedge clk);
    // R1
    check(reqReady && !busValid && !reqDone && busStrb == 2'b00 && cycleCount == 0,
          "R1", "reset state", {reqReady, busValid, reqDone, busStrb}, 5'b10000);
    rstN = 1'b1;
    @(negedge clk);
    // directed corners
    doReq(1'b1, 4'd0,  16'd16, 2'd2, 1'b0, 32'h0, 1'b0);        // R3 aligned 4B wide
    doReq(1'b1, 4'd3,  16'd21, 2'd2, 1'b0, 32'h0, 1'b0);        // R6 odd 4B
    doReq(1'b0, 4'd15, 16'd30, 2'd2, 1'b0, 32'h0, 1'b0);        // R4 narrow max wait
    doReq(1'b1, 4'd1,  16'd41, 2'd0, 1'b0, 32'h0, 1'b0);        // R6 odd byte
    doReq(1'b1, 4'd2,  16'd43, 2'd1, 1'b1, 32'hA5C3, 1'b0);     // R8 odd halfword write
    doReq(1'b1, 4'd0,  16'd51, 2'd3, 1'b1, 32'h11223344, 1'b0); // R3 code 3
    doReq(1'b1, 4'd1,  16'd51, 2'd2, 1'b0, 32'h0, 1'b0);        // R7 read back
    doReq(1'b1, 4'd2,  16'd60, 2'd2, 1'b0, 32'h0, 1'b1);        // R11 poke, R2 ws latch
    doReq(1'b1, 4'd0,  16'd70, 2'd0, 1'b0, 32'h0, 1'b0);        // R5 even byte
    void'($urandom(32'd20240611));
    for (int t = 0; t < 80; t++) begin
      doReq(1'($urandom), 4'($urandom_range(0, 5)), 16'($urandom_range(0, 250)),
            2'($urandom), 1'($urandom), $urandom, 1'b0);
    end
    finished = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
    end
  end

endmodule